// File: doc/BRIEF.md
# Logic IC Test Vector Engine

This block applies a single test vector to the pins of a chip under test, up to 40 of them, and returns the logic level it reads back on each pin. A controller hands it a parsed command in one go: a configuration byte that carries the pull direction and a supply level index, a pin count, a 32-bit sequence number, a 24-byte vector packed four bits per pin, and a settle time in clock cycles. A one-cycle start strobe launches the test.

The engine sets per-pin output enables and drive values, selects pull-up or pull-down for every undriven pin, and marks which pins carry supply or ground. It then waits, gives each clock-coded pin one high pulse, waits again, and samples the pin inputs into a reply that uses the same nibble packing as the vector. A zero sequence number starts a fresh setup, which reapplies the supply level and the supply and ground pins and releases the programming-header pins. A non-zero sequence number keeps that setup from the previous test.

Top module: `ltv_engine`

## Requirements
- R1: A start with a pin count that is odd, below 2 or above 40 is refused. On the next cycle `err_o` and `done_o` are both high for one cycle, and no pin output, supply or ground assignment changes.
- R2: Pin k (counted from 0) takes its code from vector bits [4k+3:4k], so byte 0 bits [3:0] are the first pin. Pins at index pin count or above are left undriven.
- R3: Code 0 drives the pin low and code 1 drives it high, both with the output enabled. Codes 2, 3, 5 and 6 (L, H, Z, X), and the undefined codes 9 to 15, leave the pin undriven. The pin output is never high on a pin whose enable is low.
- R4: Code 4 (C) drives the pin low with the output enabled, except for exactly one cycle of high drive between start and done.
- R5: With a zero sequence number, pins coded 7 (G) become ground pins and pins coded 8 (V) become supply pins, with no check of whether the pin can carry supply. All other pins lose any such role, and none of these pins is driven. `vcc_sel_o` takes configuration bits [1:0], where 0 selects 5 V, 1 selects 3.3 V, 2 selects 2.5 V and 3 selects 1.8 V. `isp_release_o` pulses for one cycle.
- R6: With a non-zero sequence number, `vcc_pin_o`, `gnd_pin_o` and `vcc_sel_o` keep their values, and `isp_release_o` stays low.
- R7: Every accepted test sets `pull_dn_o` to configuration bit 7, where 1 means pull-down and 0 means pull-up.
- R8: With a settle value S latched at start, `done_o` is high for one cycle, 2S+3 clock edges after the edge that accepts start. The reply is captured on that same edge. Pin drives then hold until the next accepted test.
- R9: Reply nibble k is {3'b000, pin k input} for k below the pin count, and zero for all other nibbles up to 48.
- R10: A start that arrives while `busy_o` is high is ignored. It raises no error and does not disturb the running test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| cfg_i | input | 8 | Bit 7 selects pull-down, bits [1:0] select the supply level |
| pin_cnt_i | input | 8 | Number of pins on the chip under test |
| seq_num_i | input | 32 | Sequence number; zero means a fresh supply setup |
| vec_i | input | 192 | Vector, one nibble per pin, first pin in the lowest nibble |
| settle_i | input | 16 | Settle time in cycles |
| pin_in_i | input | 40 | Sampled pin levels |
| pin_oe_o | output | 40 | Per-pin output enable |
| pin_out_o | output | 40 | Per-pin drive value |
| pull_dn_o | output | 1 | 1 for pull-down, 0 for pull-up |
| vcc_pin_o | output | 40 | Pins assigned to supply |
| gnd_pin_o | output | 40 | Pins assigned to ground |
| vcc_sel_o | output | 2 | Supply level index |
| isp_release_o | output | 1 | One-cycle pulse that returns programming-header pins to input |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle strobe when the reply is valid |
| err_o | output | 1 | One-cycle strobe when a pin count is refused |
| reply_o | output | 192 | Sampled pin levels, same nibble layout as the vector |

## Verification
The hardest case to reach is the interaction between tests. The keep-setup path only shows anything if an earlier fresh setup left non-zero supply and ground pins and a level index other than the reset value. The bench therefore chains scenarios in a fixed order: a fresh setup with a mixed vector, then tests with a non-zero sequence number whose vectors would assign different pins. A start strobe is also injected in the middle of a long settle window to show that a running test cannot be disturbed.

// File: rtl/ltv_pkg.sv
package ltv_pkg;
  localparam logic [3:0] SYM_0 = 4'd0;
  localparam logic [3:0] SYM_1 = 4'd1;
  localparam logic [3:0] SYM_C = 4'd4;
  localparam logic [3:0] SYM_G = 4'd7;
  localparam logic [3:0] SYM_V = 4'd8;

  typedef struct packed {
    logic oe;
    logic val;
    logic clk;
    logic gnd;
    logic vcc;
  } pin_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE_A,
    ST_PULSE,
    ST_SETTLE_B
  } seq_st_e;
endpackage

// File: rtl/ltv_pin_decode.sv
module ltv_pin_decode
  import ltv_pkg::*;
(
  input  logic [3:0] code_i,
  input  logic       used_i,
  output pin_ctl_t   ctl_o
);
  always_comb begin
    ctl_o = '0;
    if (used_i) begin
      case (code_i)
        SYM_0: ctl_o.oe = 1'b1;
        SYM_1: begin ctl_o.oe = 1'b1; ctl_o.val = 1'b1; end
        SYM_C: begin ctl_o.oe = 1'b1; ctl_o.clk = 1'b1; end
        SYM_G: ctl_o.gnd = 1'b1;
        SYM_V: ctl_o.vcc = 1'b1;
        default: ; // L, H, Z, X and undefined codes: input with pull
      endcase
    end
  end
endmodule

// File: rtl/ltv_seq.sv
module ltv_seq
  import ltv_pkg::*;
#(
  parameter int SETTLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                ok_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic                apply_o,
  output logic                reject_o,
  output logic                pulse_o,
  output logic                sample_o,
  output logic                busy_o
);
  seq_st_e             st_q;
  logic [SETTLE_W-1:0] cnt_q, settle_q;
  logic                cnt_end;

  assign cnt_end  = (cnt_q == settle_q);
  assign busy_o   = (st_q != ST_IDLE);
  assign apply_o  = !busy_o && start_i && ok_i;
  assign reject_o = !busy_o && start_i && !ok_i;
  assign pulse_o  = (st_q == ST_PULSE);
  assign sample_o = (st_q == ST_SETTLE_B) && cnt_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      settle_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (apply_o) begin
          st_q     <= ST_SETTLE_A;
          cnt_q    <= '0;
          settle_q <= settle_i;
        end
        ST_SETTLE_A: if (cnt_end) st_q <= ST_PULSE;
                     else         cnt_q <= cnt_q + 1'b1;
        ST_PULSE: begin
          st_q  <= ST_SETTLE_B;
          cnt_q <= '0;
        end
        ST_SETTLE_B: if (cnt_end) st_q <= ST_IDLE;
                     else         cnt_q <= cnt_q + 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ltv_engine.sv
module ltv_engine
  import ltv_pkg::*;
#(
  parameter int NPINS     = 40,
  parameter int VEC_BYTES = 24,
  parameter int SETTLE_W  = 16,
  parameter int VSEL_W    = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [7:0]             cfg_i,
  input  logic [7:0]             pin_cnt_i,
  input  logic [31:0]            seq_num_i,
  input  logic [VEC_BYTES*8-1:0] vec_i,
  input  logic [SETTLE_W-1:0]    settle_i,
  input  logic [NPINS-1:0]       pin_in_i,
  output logic [NPINS-1:0]       pin_oe_o,
  output logic [NPINS-1:0]       pin_out_o,
  output logic                   pull_dn_o,
  output logic [NPINS-1:0]       vcc_pin_o,
  output logic [NPINS-1:0]       gnd_pin_o,
  output logic [VSEL_W-1:0]      vcc_sel_o,
  output logic                   isp_release_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [VEC_BYTES*8-1:0] reply_o
);
  localparam int         VEC_W   = VEC_BYTES * 8;
  localparam int         NIB     = VEC_BYTES * 2;
  localparam logic [7:0] MAX_CNT = 8'(NPINS);

  logic             count_ok, fresh;
  logic             apply, reject, pulse, sample;
  logic [NPINS-1:0] oe_d, val_d, clk_d, gnd_d, vcc_d;
  logic [NPINS-1:0] oe_q, val_q, clk_q;
  logic [7:0]       cnt_q;
  logic [VEC_W-1:0] rep_d;

  assign count_ok = !pin_cnt_i[0] && (pin_cnt_i >= 8'd2) && (pin_cnt_i <= MAX_CNT);
  assign fresh    = (seq_num_i == 32'd0);

  ltv_seq #(.SETTLE_W(SETTLE_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .ok_i     (count_ok),
    .settle_i (settle_i),
    .apply_o  (apply),
    .reject_o (reject),
    .pulse_o  (pulse),
    .sample_o (sample),
    .busy_o   (busy_o)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_ctl_t ctl;
    ltv_pin_decode u_dec (
      .code_i (vec_i[4*p +: 4]),
      .used_i (8'(p) < pin_cnt_i),
      .ctl_o  (ctl)
    );
    assign oe_d[p]  = ctl.oe;
    assign val_d[p] = ctl.val;
    assign clk_d[p] = ctl.clk;
    assign gnd_d[p] = ctl.gnd;
    assign vcc_d[p] = ctl.vcc;
  end

  for (genvar n = 0; n < NIB; n++) begin : g_rep
    if (n < NPINS) begin : g_live
      assign rep_d[4*n +: 4] = (8'(n) < cnt_q) ? {3'b000, pin_in_i[n]} : 4'h0;
    end else begin : g_dead
      assign rep_d[4*n +: 4] = 4'h0;
    end
  end

  if (VEC_W > 4*NPINS) begin : g_spare
    logic unused_bits;
    assign unused_bits = ^{vec_i[VEC_W-1:4*NPINS], cfg_i[6:VSEL_W]};
  end else begin : g_nospare
    logic unused_bits;
    assign unused_bits = ^cfg_i[6:VSEL_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q          <= '0;
      val_q         <= '0;
      clk_q         <= '0;
      vcc_pin_o     <= '0;
      gnd_pin_o     <= '0;
      vcc_sel_o     <= '0;
      pull_dn_o     <= 1'b0;
      isp_release_o <= 1'b0;
      cnt_q         <= '0;
      done_o        <= 1'b0;
      err_o         <= 1'b0;
      reply_o       <= '0;
    end else begin
      isp_release_o <= apply && fresh;
      done_o        <= sample || reject;
      err_o         <= reject;
      if (apply) begin
        oe_q      <= oe_d;
        val_q     <= val_d;
        clk_q     <= clk_d;
        pull_dn_o <= cfg_i[7];
        cnt_q     <= pin_cnt_i;
        if (fresh) begin
          vcc_pin_o <= vcc_d;
          gnd_pin_o <= gnd_d;
          vcc_sel_o <= cfg_i[VSEL_W-1:0];
        end
      end
      if (sample) reply_o <= rep_d;
    end
  end

  assign pin_oe_o  = oe_q;
  assign pin_out_o = val_q | (clk_q & {NPINS{pulse}});
endmodule

// File: rtl/ltv_engine_chk.sv
module ltv_engine_chk #(
  parameter int NPINS     = 40,
  parameter int VEC_BYTES = 24,
  parameter int VSEL_W    = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic [7:0]             cfg_i,
  input logic [7:0]             pin_cnt_i,
  input logic [31:0]            seq_num_i,
  input logic                   busy_o,
  input logic [NPINS-1:0]       pin_oe_o,
  input logic [NPINS-1:0]       pin_out_o,
  input logic                   pull_dn_o,
  input logic [NPINS-1:0]       vcc_pin_o,
  input logic [NPINS-1:0]       gnd_pin_o,
  input logic [VSEL_W-1:0]      vcc_sel_o,
  input logic                   isp_release_o,
  input logic                   done_o,
  input logic                   err_o,
  input logic [VEC_BYTES*8-1:0] reply_o
);
  localparam int REP_W = VEC_BYTES * 8;

  function automatic logic [REP_W-1:0] hi_mask();
    logic [REP_W-1:0] m = '0;
    for (int k = 0; k < VEC_BYTES*2; k++) m[4*k+1 +: 3] = 3'b111;
    return m;
  endfunction
  localparam logic [REP_W-1:0] HI_MASK = hi_mask();

  logic take, good;
  assign take = start_i && !busy_o;
  assign good = !pin_cnt_i[0] && pin_cnt_i >= 8'd2 && pin_cnt_i <= 8'(NPINS);

  assert_reject_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !good |=> err_o && done_o && $stable(pin_oe_o) && $stable(pin_out_o)
                      && $stable(vcc_pin_o) && $stable(gnd_pin_o));

  assert_drive_needs_oe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~pin_oe_o) == '0);

  assert_fresh_setup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && good && seq_num_i == 32'd0 |=> isp_release_o && vcc_sel_o == $past(cfg_i[VSEL_W-1:0]));

  assert_keep_setup_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && good && seq_num_i != 32'd0 |=> $stable(vcc_pin_o) && $stable(gnd_pin_o)
                                           && $stable(vcc_sel_o) && !isp_release_o);

  assert_pull_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && good |=> pull_dn_o == $past(cfg_i[7]));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_reply_binary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reply_o & HI_MASK) == '0);

  assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> !err_o);
endmodule

bind ltv_engine ltv_engine_chk #(
  .NPINS(NPINS), .VEC_BYTES(VEC_BYTES), .VSEL_W(VSEL_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cfg_i(cfg_i),
  .pin_cnt_i(pin_cnt_i), .seq_num_i(seq_num_i), .busy_o(busy_o),
  .pin_oe_o(pin_oe_o), .pin_out_o(pin_out_o), .pull_dn_o(pull_dn_o),
  .vcc_pin_o(vcc_pin_o), .gnd_pin_o(gnd_pin_o), .vcc_sel_o(vcc_sel_o),
  .isp_release_o(isp_release_o), .done_o(done_o), .err_o(err_o), .reply_o(reply_o)
);

// File: tb/ltv_engine_tb_top.sv
`timescale 1ns/1ps
module ltv_engine_tb_top;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [7:0]   cfg_i = '0;
  logic [7:0]   pin_cnt_i = '0;
  logic [31:0]  seq_num_i = '0;
  logic [191:0] vec_i = '0;
  logic [15:0]  settle_i = '0;
  logic [39:0]  pin_in_i = '0;
  logic [39:0]  pin_oe_o, pin_out_o, vcc_pin_o, gnd_pin_o;
  logic         pull_dn_o, isp_release_o, busy_o, done_o, err_o;
  logic [1:0]   vcc_sel_o;
  logic [191:0] reply_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [39:0] e_vcc = '0, e_gnd = '0;
  logic [1:0]  e_sel = '0;

  always #2.5 clk = ~clk;

  ltv_engine dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cfg_i(cfg_i),
    .pin_cnt_i(pin_cnt_i), .seq_num_i(seq_num_i), .vec_i(vec_i),
    .settle_i(settle_i), .pin_in_i(pin_in_i), .pin_oe_o(pin_oe_o),
    .pin_out_o(pin_out_o), .pull_dn_o(pull_dn_o), .vcc_pin_o(vcc_pin_o),
    .gnd_pin_o(gnd_pin_o), .vcc_sel_o(vcc_sel_o), .isp_release_o(isp_release_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .reply_o(reply_o)
  );

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] code_mask(input logic [191:0] v, input int cnt, input logic [3:0] c);
    logic [39:0] m = '0;
    for (int i = 0; i < 40; i++) if (i < cnt && v[4*i +: 4] == c) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [191:0] exp_reply(input logic [39:0] pins, input int cnt);
    logic [191:0] r = '0;
    for (int i = 0; i < 40; i++) if (i < cnt) r[4*i] = pins[i];
    return r;
  endfunction

  // launch one start and follow it to done
  task automatic launch(input logic [7:0] cfg, input int cnt, input logic [31:0] seq,
                        input logic [191:0] v, input int settle, input logic [39:0] cmask,
                        output int lat, output int hi, output int isp, output bit err);
    @(negedge clk);
    cfg_i = cfg; pin_cnt_i = 8'(cnt); seq_num_i = seq; vec_i = v; settle_i = 16'(settle);
    start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    lat = 0; hi = 0; isp = 0; err = 0;
    forever begin
      @(negedge clk);
      lat++;
      if ((pin_out_o & cmask) != '0) hi++;
      if (isp_release_o) isp++;
      if (done_o) begin err = err_o; break; end
      if (lat > 5000) break;
    end
  endtask

  task automatic run_good(input string tag, input logic [7:0] cfg, input int cnt, input logic [31:0] seq,
                          input logic [191:0] v, input int settle, input logic [39:0] pins);
    int lat, hi, isp; bit err;
    logic [39:0] cm, e_oe, e_out;
    cm    = code_mask(v, cnt, 4'd4);
    e_oe  = code_mask(v, cnt, 4'd0) | code_mask(v, cnt, 4'd1) | cm;
    e_out = code_mask(v, cnt, 4'd1);
    pin_in_i = pins;
    launch(cfg, cnt, seq, v, settle, cm, lat, hi, isp, err);
    if (seq == 0) begin
      e_vcc = code_mask(v, cnt, 4'd8);
      e_gnd = code_mask(v, cnt, 4'd7);
      e_sel = cfg[1:0];
    end
    chk(lat == 2*settle + 4, {tag, " R8 latency"}, 192'(lat), 192'(2*settle + 4));
    chk(!err, {tag, " R1 no error"}, 192'(err), 0);
    chk(pin_oe_o == e_oe, {tag, " R2 R3 oe"}, 192'(pin_oe_o), 192'(e_oe));
    chk(pin_out_o == e_out, {tag, " R3 R4 drive"}, 192'(pin_out_o), 192'(e_out));
    chk(hi == ((cm != 0) ? 1 : 0), {tag, " R4 clock pulse"}, 192'(hi), 192'((cm != 0) ? 1 : 0));
    chk(pull_dn_o == cfg[7], {tag, " R7 pull"}, 192'(pull_dn_o), 192'(cfg[7]));
    chk(vcc_pin_o == e_vcc && gnd_pin_o == e_gnd, {tag, " R5 R6 supply pins"},
        192'({vcc_pin_o, gnd_pin_o}), 192'({e_vcc, e_gnd}));
    chk(vcc_sel_o == e_sel, {tag, " R5 R6 level"}, 192'(vcc_sel_o), 192'(e_sel));
    chk(isp == ((seq == 0) ? 1 : 0), {tag, " R5 R6 release"}, 192'(isp), 192'((seq == 0) ? 1 : 0));
    chk(reply_o == exp_reply(pins, cnt), {tag, " R9 reply"}, reply_o, exp_reply(pins, cnt));
  endtask

  task automatic t_reset();
    chk(pin_oe_o == 0 && pin_out_o == 0 && vcc_pin_o == 0 && gnd_pin_o == 0,
        "reset R8 pins idle", 192'({pin_oe_o, pin_out_o}), 0);
    chk(!busy_o && !done_o && !err_o && reply_o == 0, "reset R8 flags",
        192'({busy_o, done_o, err_o}), 0);
  endtask

  task automatic t_mixed_fresh();
    logic [191:0] v = '0;
    for (int i = 0; i < 40; i++) v[4*i +: 4] = 4'(i % 16);
    run_good("mixed", 8'h82, 40, 32'd0, v, 3, 40'hA5_3C0F_96E1);
  endtask

  task automatic t_partial_keep();
    logic [191:0] v = {48{4'h1}};
    run_good("partial", 8'h01, 6, 32'd1, v, 0, 40'hFF_FFFF_FFFF);
  endtask

  task automatic t_supply_ignored();
    logic [191:0] v = {48{4'h8}};
    run_good("keepsup", 8'h83, 40, 32'd9, v, 2, 40'h00_0000_0001);
  endtask

  task automatic t_fresh_clear();
    logic [191:0] v = '0;
    v[4*1 +: 4] = 4'd4; v[4*2 +: 4] = 4'd7; v[4*3 +: 4] = 4'd8; v[4*10 +: 4] = 4'd8;
    run_good("fresh2", 8'h01, 12, 32'd0, v, 5, 40'h55_5555_5555);
  endtask

  task automatic t_reject(input int cnt);
    int lat, hi, isp; bit err;
    logic [39:0] oe0, out0, vcc0, gnd0;
    oe0 = pin_oe_o; out0 = pin_out_o; vcc0 = vcc_pin_o; gnd0 = gnd_pin_o;
    launch(8'h80, cnt, 32'd0, {48{4'h1}}, 4, '0, lat, hi, isp, err);
    chk(err && lat == 1, $sformatf("R1 reject cnt=%0d", cnt), 192'({err, 8'(lat)}), 192'({1'b1, 8'd1}));
    chk(pin_oe_o == oe0 && pin_out_o == out0 && vcc_pin_o == vcc0 && gnd_pin_o == gnd0 && isp == 0,
        $sformatf("R1 pins kept cnt=%0d", cnt), 192'(pin_oe_o), 192'(oe0));
  endtask

  task automatic t_busy_start();
    int n = 0; bit seen_err = 0;
    logic [191:0] v = {48{4'h0}};
    pin_in_i = 40'hF0_F0F0_F0F0;
    @(negedge clk);
    cfg_i = 8'h00; pin_cnt_i = 8'd8; seq_num_i = 32'd3; vec_i = v; settle_i = 16'd20; start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    repeat (4) @(negedge clk);
    pin_cnt_i = 8'd3; vec_i = {48{4'h1}}; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    forever begin
      @(negedge clk); n++;
      if (err_o) seen_err = 1;
      if (done_o || n > 500) break;
    end
    chk(!seen_err, "R10 no error from busy start", 192'(seen_err), 0);
    chk(pin_oe_o == 40'hFF && pin_out_o == 0, "R10 first test kept", 192'(pin_oe_o), 192'(40'hFF));
    chk(reply_o == exp_reply(40'hF0_F0F0_F0F0, 8), "R10 R9 reply", reply_o, exp_reply(40'hF0_F0F0_F0F0, 8));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed_fresh();
    t_partial_keep();
    t_supply_ignored();
    t_reject(7);
    t_reject(0);
    t_reject(42);
    t_fresh_clear();
    t_busy_start();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule